// File: doc/BRIEF.md
# Bundle Lane Legality Gate

This block sits in the decode stage of a small in-order core that runs explicitly bundled long-instruction-word code. Each cycle it may receive a bundle of up to three pre-decoded instruction slots. Each slot carries a valid bit, an operation class, a flag that marks a convert operation as part of the restricted subset, one destination register with a write enable, and two source register fields. The second source field can be flagged as holding immediate bits.

A two-bit pipeline mode, set earlier by a mode-select instruction, says how wide software expects the machine to be. Mode 0 allows only scalar issue, mode 1 has two lanes and mode 2 has three. The lanes have fixed and uneven abilities. The gate decides whether the bundle may issue in parallel and assigns a lane to each slot. When the bundle breaks a lane rule, holds an intra-bundle read-after-write conflict, or declares a mode wider than the hardware provides, the core does not fault: it falls back to scalar issue, and the gate raises a flag to say so. All outputs are registered one cycle after the input.

Top module: `liw_issue_gate`

## Requirements
- R1: While reset is low, and after it, until the first valid input, `out_valid`, `lane_sel`, `par_issue` and `fallback` are all zero.
- R2: The outputs for an input appear on the first rising edge after it is presented, with `out_valid` set. A cycle with `in_valid` low yields `out_valid`, `lane_sel`, `par_issue` and `fallback` all zero on the next edge.
- R3: When only slot 0 is valid, the result is `lane_sel` = 6'b000001 with `par_issue` and `fallback` low, in every mode.
- R4: In mode 0, a bundle with more than one valid slot always gives `fallback`.
- R5: In mode 1, at most two slots may issue together. Lane 2 takes class ALU (0), shift (1) or convert (2). A memory operation (class 3) in slot 0 together with any other slot gives `fallback`.
- R6: In mode 2, lane 3 takes only ALU, or a convert whose `slot_cvt_lite` bit is set. Shift and every other class there give `fallback`.
- R7: Memory (3), branch (4) and compare (5) operations may issue only in lane 1. Any of them in slot 1 or slot 2 of a multi-slot bundle gives `fallback`.
- R8: In mode 2, a memory operation in slot 0 may issue with one more slot, but not with two.
- R9: An FPU operation (class 6) in slot 1 is accepted in lane 2 only when slot 0 is not an FPU operation.
- R10: If an earlier valid slot writes a register that a later valid slot reads, the result is `fallback`. A second source flagged by `slot_src_b_imm` is never compared.
- R11: A multi-slot bundle whose mode exceeds the parameter `HW_MAX_MODE` (default 2, so mode 3) gives `fallback`.
- R12: Lane code for slot i is `lane_sel[2i+1:2i]`: 0 means not issued, 1, 2 and 3 mean lane 1, 2 and 3. On parallel issue slot i gets code i+1. On fallback every valid slot gets code 1 and every invalid slot gets 0. `par_issue` and `fallback` are never high together.
- R13: A valid pattern with a hole, one that is not 001, 011 or 111, gives `fallback`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bundle present this cycle |
| mode | input | 2 | Declared pipeline mode |
| slot_vld | input | 3 | Per-slot valid |
| slot_cls | input | 9 | Class per slot, 3 bits each, slot i at [3i+2:3i] |
| slot_cvt_lite | input | 3 | Convert belongs to the lane-3 subset |
| slot_dst_we | input | 3 | Slot writes its destination |
| slot_dst | input | 15 | Destination register per slot, 5 bits each |
| slot_src_a | input | 15 | First source register per slot |
| slot_src_b | input | 15 | Second source register per slot |
| slot_src_b_imm | input | 3 | Second source field holds immediate bits |
| out_valid | output | 1 | Registered result valid |
| lane_sel | output | 6 | Lane code per slot, 2 bits each |
| par_issue | output | 1 | Bundle issues in parallel |
| fallback | output | 1 | Bundle falls back to scalar issue |

## Verification
The hardest situation to reach is a bundle that passes every lane rule and still falls back, because a later slot reads what an earlier slot writes. The check is also hard to satisfy when the only match lies in an immediate-flagged field, which must not count. Uniform random classes almost never yield a legal three-slot mode-2 bundle, so the random stimulus draws register numbers from a narrow range to make collisions common. Directed cases build legal bundles by hand and then place a single match on the first source, on a flagged second source and on an unflagged second source.

// File: rtl/liw_issue_pkg.sv
package liw_issue_pkg;

  localparam int NUM_SLOTS = 3;
  localparam int CLS_W     = 3;
  localparam int LANE_W    = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU = 3'd0,
    CLS_SHF = 3'd1,
    CLS_CVT = 3'd2,
    CLS_MEM = 3'd3,
    CLS_BRA = 3'd4,
    CLS_CMP = 3'd5,
    CLS_FPU = 3'd6,
    CLS_OTH = 3'd7
  } op_class_e;

  typedef logic [LANE_W-1:0] lane_code_t;

  // Whether the lane with index `lane` (0 = lane 1) accepts an operation.
  function automatic logic lane_accepts(input int lane, input op_class_e cls,
                                        input logic cvt_lite, input logic head_fpu);
    logic ok;
    ok = 1'b0;
    if (lane == 0) begin
      ok = 1'b1;
    end else if (lane == 1) begin
      ok = (cls == CLS_ALU) || (cls == CLS_SHF) || (cls == CLS_CVT) ||
           ((cls == CLS_FPU) && !head_fpu);
    end else begin
      ok = (cls == CLS_ALU) || ((cls == CLS_CVT) && cvt_lite);
    end
    return ok;
  endfunction

  // Number of lanes a mode asks for.
  function automatic logic [2:0] lanes_of_mode(input logic [1:0] m);
    return {1'b0, m} + 3'd1;
  endfunction

endpackage

// File: rtl/liw_lane_gate.sv
module liw_lane_gate
  import liw_issue_pkg::*;
#(
  parameter int SLOTS = NUM_SLOTS
) (
  input  logic [SLOTS-1:0]       vld,
  input  logic [SLOTS*CLS_W-1:0] cls,
  input  logic [SLOTS-1:0]       cvt_lite,
  output logic [SLOTS-1:0]       lane_ok,
  output logic                   head_mem
);

  logic head_fpu;
  assign head_fpu = vld[0] && (op_class_e'(cls[CLS_W-1:0]) == CLS_FPU);
  assign head_mem = vld[0] && (op_class_e'(cls[CLS_W-1:0]) == CLS_MEM);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    op_class_e c;
    assign c = op_class_e'(cls[s*CLS_W +: CLS_W]);
    assign lane_ok[s] = !vld[s] || lane_accepts(s, c, cvt_lite[s], head_fpu);
  end

endmodule

// File: rtl/liw_raw_scan.sv
module liw_raw_scan #(
  parameter int SLOTS = 3,
  parameter int REG_W = 5
) (
  input  logic [SLOTS-1:0]       vld,
  input  logic [SLOTS-1:0]       dst_we,
  input  logic [SLOTS*REG_W-1:0] dst,
  input  logic [SLOTS*REG_W-1:0] src_a,
  input  logic [SLOTS*REG_W-1:0] src_b,
  input  logic [SLOTS-1:0]       src_b_imm,
  output logic                   raw_hit
);

  localparam int PAIRS = SLOTS * SLOTS;
  logic [PAIRS-1:0] pair_hit;

  for (genvar w = 0; w < SLOTS; w++) begin : g_wr
    for (genvar r = 0; r < SLOTS; r++) begin : g_rd
      if (w < r) begin : g_later
        logic [REG_W-1:0] d;
        logic             hit_a;
        logic             hit_b;
        assign d     = dst[w*REG_W +: REG_W];
        assign hit_a = (d == src_a[r*REG_W +: REG_W]);
        assign hit_b = !src_b_imm[r] && (d == src_b[r*REG_W +: REG_W]);
        assign pair_hit[w*SLOTS+r] = vld[w] && vld[r] && dst_we[w] && (hit_a || hit_b);
      end else begin : g_none
        assign pair_hit[w*SLOTS+r] = 1'b0;
      end
    end
  end

  assign raw_hit = |pair_hit;

endmodule

// File: rtl/liw_issue_gate.sv
module liw_issue_gate
  import liw_issue_pkg::*;
#(
  parameter int unsigned HW_MAX_MODE = 2,
  parameter int          REG_W       = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [1:0]                 mode,
  input  logic [NUM_SLOTS-1:0]       slot_vld,
  input  logic [NUM_SLOTS*CLS_W-1:0] slot_cls,
  input  logic [NUM_SLOTS-1:0]       slot_cvt_lite,
  input  logic [NUM_SLOTS-1:0]       slot_dst_we,
  input  logic [NUM_SLOTS*REG_W-1:0] slot_dst,
  input  logic [NUM_SLOTS*REG_W-1:0] slot_src_a,
  input  logic [NUM_SLOTS*REG_W-1:0] slot_src_b,
  input  logic [NUM_SLOTS-1:0]       slot_src_b_imm,
  output logic                       out_valid,
  output logic [NUM_SLOTS*LANE_W-1:0] lane_sel,
  output logic                       par_issue,
  output logic                       fallback
);

  localparam int SEL_W = NUM_SLOTS * LANE_W;

  // Named internal events
  logic [NUM_SLOTS-1:0] lane_ok;
  logic                 head_mem;
  logic                 raw_hit;
  logic [1:0]           slot_cnt;
  logic                 any_vld;
  logic                 solo;
  logic                 shape_ok;
  logic                 mode_bad;
  logic                 too_wide;
  logic                 mem_crowd;
  logic                 rules_ok;
  logic                 legal;
  logic [SEL_W-1:0]     lane_d;
  logic                 par_d;
  logic                 fb_d;

  liw_lane_gate #(.SLOTS(NUM_SLOTS)) u_lanes (
    .vld      (slot_vld),
    .cls      (slot_cls),
    .cvt_lite (slot_cvt_lite),
    .lane_ok  (lane_ok),
    .head_mem (head_mem)
  );

  liw_raw_scan #(.SLOTS(NUM_SLOTS), .REG_W(REG_W)) u_raw (
    .vld       (slot_vld),
    .dst_we    (slot_dst_we),
    .dst       (slot_dst),
    .src_a     (slot_src_a),
    .src_b     (slot_src_b),
    .src_b_imm (slot_src_b_imm),
    .raw_hit   (raw_hit)
  );

  assign slot_cnt  = {1'b0, slot_vld[0]} + {1'b0, slot_vld[1]} + {1'b0, slot_vld[2]};
  assign any_vld   = |slot_vld;
  assign solo      = (slot_vld == 3'b001);
  assign shape_ok  = (slot_vld == 3'b011) || (slot_vld == 3'b111);
  assign mode_bad  = (32'(mode) > HW_MAX_MODE) || (mode == 2'd0);
  assign too_wide  = {1'b0, slot_cnt} > lanes_of_mode(mode);
  // A memory op in lane 1 consumes the last lane of the active mode.
  assign mem_crowd = head_mem && (slot_cnt > mode);
  assign rules_ok  = &lane_ok;
  assign legal     = shape_ok && !mode_bad && !too_wide && !mem_crowd &&
                     rules_ok && !raw_hit;

  always_comb begin
    lane_d = '0;
    par_d  = 1'b0;
    fb_d   = 1'b0;
    if (solo) begin
      lane_d[LANE_W-1:0] = lane_code_t'(1);
    end else if (any_vld) begin
      par_d = legal;
      fb_d  = !legal;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (slot_vld[s]) begin
          lane_d[s*LANE_W +: LANE_W] = legal ? lane_code_t'(s + 1) : lane_code_t'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      lane_sel  <= '0;
      par_issue <= 1'b0;
      fallback  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        lane_sel  <= lane_d;
        par_issue <= par_d;
        fallback  <= fb_d;
      end else begin
        lane_sel  <= '0;
        par_issue <= 1'b0;
        fallback  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/liw_issue_gate_chk.sv
module liw_issue_gate_chk #(
  parameter int unsigned HW_MAX_MODE = 2,
  parameter int          REG_W       = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [1:0]         mode,
  input logic [2:0]         slot_vld,
  input logic [8:0]         slot_cls,
  input logic [3*REG_W-1:0] slot_dst,
  input logic               out_valid,
  input logic [5:0]         lane_sel,
  input logic               par_issue,
  input logic               fallback
);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && lane_sel == 6'd0 && !par_issue && !fallback));

  p_solo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && slot_vld == 3'b001) |=> (lane_sel == 6'b000001 && !par_issue && !fallback));

  p_scalar_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'd0 && $countones(slot_vld) > 1) |=> fallback);

  p_head_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && slot_vld[1] && (slot_cls[5:3] == 3'd3 || slot_cls[5:3] == 3'd4 ||
     slot_cls[5:3] == 3'd5)) |=> !par_issue);

  p_hw_limit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && 32'(mode) > HW_MAX_MODE && $countones(slot_vld) > 1) |=> fallback);

  p_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(par_issue && fallback));

  p_par_lanes_r12: assert property (@(posedge clk) disable iff (!rst_n)
    par_issue |-> (lane_sel[1:0] == 2'd1 && lane_sel[3:2] == 2'd2 &&
                   (lane_sel[5:4] == 2'd0 || lane_sel[5:4] == 2'd3)));

  p_fb_lanes_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fallback |-> (lane_sel[3:2] != 2'd2 && lane_sel[3:2] != 2'd3 &&
                  lane_sel[5:4] != 2'd2 && lane_sel[5:4] != 2'd3));

  p_holes_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (slot_vld == 3'b101 || slot_vld == 3'b110)) |=> fallback);

endmodule

bind liw_issue_gate liw_issue_gate_chk #(.HW_MAX_MODE(HW_MAX_MODE), .REG_W(REG_W)) u_chk (.*);

// File: tb/sim_liw_issue_gate.sv
module sim_liw_issue_gate;

  localparam int HWM = 2;
  localparam int RW  = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = '0;
  logic [2:0]  slot_vld = '0;
  logic [8:0]  slot_cls = '0;
  logic [2:0]  slot_cvt_lite = '0;
  logic [2:0]  slot_dst_we = '0;
  logic [14:0] slot_dst = '0;
  logic [14:0] slot_src_a = '0;
  logic [14:0] slot_src_b = '0;
  logic [2:0]  slot_src_b_imm = '0;
  logic        out_valid;
  logic [5:0]  lane_sel;
  logic        par_issue;
  logic        fallback;

  always #4 clk = ~clk;

  liw_issue_gate #(.HW_MAX_MODE(HWM), .REG_W(RW)) u0 (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // stimulus staging
  logic       s_valid;
  logic [1:0] s_mode;
  logic [2:0] s_vld, s_lite, s_we, s_imm;
  logic [2:0] s_cls [3];
  logic [4:0] s_dst [3];
  logic [4:0] s_sa [3];
  logic [4:0] s_sb [3];

  logic [8:0] e_vec;
  string      e_tag;
  bit         pending = 1'b0;

  function automatic bool_t_dummy(); return 0; endfunction

  function automatic bit is_head_only(input logic [2:0] c);
    return c == 3'd3 || c == 3'd4 || c == 3'd5;
  endfunction

  // Reference: returns {out_valid, lane_sel, par, fb}
  function automatic logic [8:0] ref_model(output string tag);
    int  n;
    bit  ok;
    logic [5:0] ls;
    tag = "R12";
    ok  = 1'b1;
    if (!s_valid) begin tag = "R2"; return 9'd0; end
    n = $countones(s_vld);
    if (s_vld == 3'b000) return 9'b1_000000_00;
    if (s_vld == 3'b001) begin tag = "R3"; return 9'b1_000001_00; end
    if (s_vld != 3'b011 && s_vld != 3'b111) begin ok = 0; tag = "R13"; end
    else if (s_mode == 2'd0) begin ok = 0; tag = "R4"; end
    else if (int'(s_mode) > HWM) begin ok = 0; tag = "R11"; end
    else if (n > int'(s_mode) + 1) begin ok = 0; tag = "R5"; end
    else begin
      if (is_head_only(s_cls[1])) begin ok = 0; tag = "R7"; end
      else if (s_cls[1] == 3'd6 && s_cls[0] == 3'd6) begin ok = 0; tag = "R9"; end
      else if (s_cls[1] == 3'd7) begin ok = 0; tag = "R5"; end
      if (ok && n == 3) begin
        if (is_head_only(s_cls[2])) begin ok = 0; tag = "R7"; end
        else if (!(s_cls[2] == 3'd0 || (s_cls[2] == 3'd2 && s_lite[2]))) begin ok = 0; tag = "R6"; end
      end
      if (ok && s_cls[0] == 3'd3 && n > int'(s_mode)) begin
        ok = 0; tag = (s_mode == 2'd1) ? "R5" : "R8";
      end
      if (ok) begin
        for (int w = 0; w < 3; w++)
          for (int r = w + 1; r < 3; r++)
            if (s_vld[w] && s_vld[r] && s_we[w] &&
                (s_dst[w] == s_sa[r] || (!s_imm[r] && s_dst[w] == s_sb[r]))) begin
              ok = 0; tag = "R10";
            end
      end
    end
    ls = '0;
    for (int s = 0; s < 3; s++)
      if (s_vld[s]) ls[2*s +: 2] = ok ? 2'(s + 1) : 2'd1;
    return {1'b1, ls, ok, !ok};
  endfunction

  task automatic step();
    logic [8:0] got;
    @(negedge clk);
    if (pending) begin
      got = {out_valid, lane_sel, par_issue, fallback};
      n_chk++;
      if (got !== e_vec) begin
        n_bad++;
        $display("FAIL %s: got v=%b lanes=%b par=%b fb=%b, expected v=%b lanes=%b par=%b fb=%b",
                 e_tag, got[8], got[7:2], got[1], got[0], e_vec[8], e_vec[7:2], e_vec[1], e_vec[0]);
      end
    end
    in_valid       = s_valid;
    mode           = s_mode;
    slot_vld       = s_vld;
    slot_cvt_lite  = s_lite;
    slot_dst_we    = s_we;
    slot_src_b_imm = s_imm;
    for (int s = 0; s < 3; s++) begin
      slot_cls[3*s +: 3]   = s_cls[s];
      slot_dst[5*s +: 5]   = s_dst[s];
      slot_src_a[5*s +: 5] = s_sa[s];
      slot_src_b[5*s +: 5] = s_sb[s];
    end
    e_vec   = ref_model(e_tag);
    pending = 1'b1;
  endtask

  task automatic base(input logic [1:0] m, input logic [2:0] v,
                      input logic [2:0] c0, input logic [2:0] c1, input logic [2:0] c2);
    s_valid = 1'b1; s_mode = m; s_vld = v;
    s_cls[0] = c0; s_cls[1] = c1; s_cls[2] = c2;
    s_lite = 3'b000; s_we = 3'b111; s_imm = 3'b000;
    for (int s = 0; s < 3; s++) begin
      s_dst[s] = 5'(10 + s);
      s_sa[s]  = 5'(20 + s);
      s_sb[s]  = 5'(25 + s);
    end
  endtask

  initial begin
    base(2'd0, 3'b000, 3'd0, 3'd0, 3'd0);
    s_valid = 1'b0;
    repeat (3) @(negedge clk);
    n_chk++;
    if ({out_valid, lane_sel, par_issue, fallback} !== 9'd0) begin
      n_bad++;
      $display("FAIL R1: got %b, expected 0", {out_valid, lane_sel, par_issue, fallback});
    end
    rst_n = 1'b1;
    step();  // idle cycle, R1 after reset
    // R3: solo memory op, mode 2
    base(2'd2, 3'b001, 3'd3, 3'd0, 3'd0); step();
    // R4: mode 0 pair
    base(2'd0, 3'b011, 3'd0, 3'd0, 3'd0); step();
    // R5: mode 1 legal pair, three slots, memory head
    base(2'd1, 3'b011, 3'd0, 3'd1, 3'd0); step();
    base(2'd1, 3'b111, 3'd0, 3'd1, 3'd0); step();
    base(2'd1, 3'b011, 3'd3, 3'd0, 3'd0); step();
    // R6: mode 2 lane 3 subset
    base(2'd2, 3'b111, 3'd0, 3'd1, 3'd2); s_lite = 3'b100; step();
    base(2'd2, 3'b111, 3'd0, 3'd1, 3'd1); step();
    base(2'd2, 3'b111, 3'd0, 3'd1, 3'd2); step();
    // R7: branch in slot 1
    base(2'd2, 3'b011, 3'd0, 3'd4, 3'd0); step();
    // R8: memory head with one or two partners
    base(2'd2, 3'b011, 3'd3, 3'd0, 3'd0); step();
    base(2'd2, 3'b111, 3'd3, 3'd0, 3'd0); step();
    // R9: FPU in lane 2
    base(2'd2, 3'b011, 3'd6, 3'd6, 3'd0); step();
    base(2'd2, 3'b011, 3'd0, 3'd6, 3'd0); step();
    // R10: read-after-write inside the bundle
    base(2'd2, 3'b111, 3'd0, 3'd0, 3'd0); s_sa[2] = 5'd10; step();
    base(2'd2, 3'b111, 3'd0, 3'd0, 3'd0); s_sb[1] = 5'd10; s_imm = 3'b010; step();
    base(2'd2, 3'b111, 3'd0, 3'd0, 3'd0); s_sb[1] = 5'd10; step();
    base(2'd2, 3'b011, 3'd0, 3'd0, 3'd0); s_sa[1] = 5'd10; s_we = 3'b110; step();
    // R11: mode beyond hardware
    base(2'd3, 3'b011, 3'd0, 3'd0, 3'd0); step();
    // R13: hole in valid pattern
    base(2'd2, 3'b101, 3'd0, 3'd0, 3'd0); step();
    // R2: idle cycle clears outputs
    s_valid = 1'b0; step();

    // Random mix, fixed seed
    void'($urandom(32'h5eed_0421));
    for (int k = 0; k < 4000; k++) begin
      int p;
      s_valid = ($urandom_range(0, 9) != 0);
      s_mode  = 2'($urandom_range(0, 3));
      p = $urandom_range(0, 9);
      s_vld = (p < 4) ? 3'b111 : (p < 7) ? 3'b011 : (p < 8) ? 3'b001 : 3'($urandom);
      for (int s = 0; s < 3; s++) begin
        p = $urandom_range(0, 9);
        s_cls[s] = (p < 4) ? 3'd0 : 3'($urandom);
        s_dst[s] = 5'($urandom_range(0, 7));
        s_sa[s]  = 5'($urandom_range(0, 7));
        s_sb[s]  = 5'($urandom_range(0, 7));
      end
      s_lite = 3'($urandom);
      s_we   = 3'($urandom);
      s_imm  = 3'($urandom);
      step();
    end
    s_valid = 1'b0;
    step();
    step();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule